// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a system timer for a chip whose time base is a 32768 Hz slow clock. The block runs on the bus clock. The slow clock reaches it as a one-cycle strobe, `slow_tick`, that has already been brought into the bus clock domain. Software reaches the timer through a small register bus with read and write strobes.

The timer has four time sources:

- A 20-bit real-time counter, advanced by a programmable prescaler. It wraps modulo 2^20.
- An absolute-time alarm. It compares for equality against the counter. Because of this, arming it at the current count does not fire until the counter has wrapped all the way round.
- A periodic interval timer that reloads itself.
- A simple down-counter that stands in for the watchdog and raises an overflow flag.

Each source sets a sticky flag in a status register, which clears when it is read. A mask register gates these flags onto one level interrupt. Software changes the mask through separate set and clear registers.

Register word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | interval period | read/write |
| 1 | watchdog load | write |
| 2 | prescaler | read/write |
| 3 | alarm | read/write |
| 4 | status | read, clears on read |
| 5 | mask set | write |
| 6 | mask clear | write |
| 7 | mask | read |
| 8 | counter | read |

Status and mask bit positions: bit 0 is the interval flag, bit 1 the watchdog flag, bit 2 the counter-increment flag and bit 3 the alarm flag.

Top module: `sys_timer`

## Requirements
- R1: The real-time counter is 20 bits wide, starts at 0 after reset, wraps modulo 2^20, and reads back at address 8.
- R2: The prescaler register is at address 2 and resets to 32768. With value N, the counter advances once every N slow ticks, and a value of 0 means 65536 ticks. Writing the prescaler restarts the tick count.
- R3: The alarm register is at address 3. Status bit 3 sets on the counter increment that makes the counter equal to the alarm value, and not before.
- R4: Writing the alarm with the counter's current value raises no alarm on the following increments; the match needs a full wrap.
- R5: The interval period register is at address 0. With period P ≠ 0, status bit 0 sets every P slow ticks. Writing the period restarts the interval count, and P = 0 stops the interval timer.
- R6: A write to address 1 loads the watchdog down-counter. Each slow tick decrements it. Status bit 1 sets when it reaches zero, and the counter then stays at zero with no further flags.
- R7: Status bit 2 sets on every counter increment.
- R8: A read of the status register at address 4 returns the flags as they were before the read and clears all of them.
- R9: A flag event in the same cycle as a status read is kept and is returned by the next status read.
- R10: Writing 1s to address 5 sets those mask bits, and writing 1s to address 6 clears them; 0 bits change nothing. The mask reads at address 7 and resets to 0.
- R11: The `irq` output is the OR of status AND mask. It changes on the same clock edge as the status or mask register it follows.
- R12: Read data appears on `bus_rdata` one cycle after the read strobe. Unused addresses read as 0, and after reset all flags are clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, registered |

## Verification
Read data is registered, so the bench drives a read on a falling edge and compares `bus_rdata` at the next falling edge, one clock later. Flags and `irq` take their new value on the rising edge that carries the causing slow tick, mask write or status read. The bench therefore samples them at the falling edge right after that last stimulus cycle. A read and a tick are placed in the same cycle only in the collision case, where the expected value is the pre-read status followed by the new event on the next read.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int ST_AW    = 4;
  localparam int ST_FLAGS = 4;

  // register word addresses
  localparam logic [ST_AW-1:0] RA_PERIOD = 4'd0;
  localparam logic [ST_AW-1:0] RA_WDOG   = 4'd1;
  localparam logic [ST_AW-1:0] RA_PRESC  = 4'd2;
  localparam logic [ST_AW-1:0] RA_ALARM  = 4'd3;
  localparam logic [ST_AW-1:0] RA_STATUS = 4'd4;
  localparam logic [ST_AW-1:0] RA_MSET   = 4'd5;
  localparam logic [ST_AW-1:0] RA_MCLR   = 4'd6;
  localparam logic [ST_AW-1:0] RA_MASK   = 4'd7;
  localparam logic [ST_AW-1:0] RA_COUNT  = 4'd8;

  // flag bit positions in status and mask
  localparam int FB_PIT = 0;
  localparam int FB_WDG = 1;
  localparam int FB_INC = 2;
  localparam int FB_ALM = 3;
endpackage

// File: rtl/st_rtc.sv
module st_rtc #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             presc_wr,
  input  logic [PRE_W-1:0] presc_wdata,
  input  logic             alarm_wr,
  input  logic [CNT_W-1:0] alarm_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [PRE_W-1:0] presc,
  output logic [CNT_W-1:0] alarm,
  output logic             inc_evt,
  output logic             alm_evt
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;
  logic [CNT_W-1:0] cnt_nxt;

  // a value of 0 wraps to all ones, giving 2^PRE_W ticks per step
  assign pre_last = presc - 1'b1;
  assign cnt_nxt  = cnt + 1'b1;
  assign inc_evt  = tick && (pre_cnt == pre_last);
  assign alm_evt  = inc_evt && (cnt_nxt == alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc   <= PRE_W'(PRE_RST);
      pre_cnt <= '0;
      cnt     <= '0;
      alarm   <= '0;
    end else begin
      if (presc_wr) begin
        presc   <= presc_wdata;
        pre_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= inc_evt ? '0 : pre_cnt + 1'b1;
      end
      if (inc_evt) cnt <= cnt_nxt;
      if (alarm_wr) alarm <= alarm_wdata;
    end
  end

  assert_cnt_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> $past(tick));
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/st_pit.sv
module st_pit #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_wdata,
  output logic [PER_W-1:0] period,
  output logic             evt
);
  logic [PER_W-1:0] elapsed;

  assign evt = tick && (period != '0) && (elapsed == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      period  <= '0;
      elapsed <= '0;
    end else if (per_wr) begin
      period  <= per_wdata;
      elapsed <= '0;
    end else if (tick && (period != '0)) begin
      elapsed <= evt ? '0 : elapsed + 1'b1;
    end
  end

  assert_pit_range_R5: assert property (@(posedge clk) disable iff (rst)
    (period != '0) |-> (elapsed < period));
endmodule

// File: rtl/st_wdog.sv
module st_wdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            ld,
  input  logic [WD_W-1:0] ld_val,
  output logic            evt
);
  logic [WD_W-1:0] remain;

  assign evt = tick && !ld && (remain == WD_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                         remain <= '0;
    else if (ld)                     remain <= ld_val;
    else if (tick && remain != '0)   remain <= remain - 1'b1;
  end

  assert_wdog_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (remain == '0 && !ld) |=> (remain == '0));
endmodule

// File: rtl/sys_timer.sv
module sys_timer #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768,
  parameter int PER_W   = 16,
  parameter int WD_W    = 16,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slow_tick,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [st_pkg::ST_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     irq
);
  import st_pkg::*;

  localparam int NF = ST_FLAGS;

  logic wr_per, wr_wd, wr_pre, wr_alm, wr_set, wr_clr, rd_sts;
  logic [CNT_W-1:0] cnt, alarm;
  logic [PRE_W-1:0] presc;
  logic [PER_W-1:0] period;
  logic inc_evt, alm_evt, pit_evt, wd_evt;
  logic [NF-1:0] set_v, sts_q, sts_d, mask_q, mask_d;
  logic unused_wdata;

  assign wr_per = bus_wr && (bus_addr == RA_PERIOD);
  assign wr_wd  = bus_wr && (bus_addr == RA_WDOG);
  assign wr_pre = bus_wr && (bus_addr == RA_PRESC);
  assign wr_alm = bus_wr && (bus_addr == RA_ALARM);
  assign wr_set = bus_wr && (bus_addr == RA_MSET);
  assign wr_clr = bus_wr && (bus_addr == RA_MCLR);
  assign rd_sts = bus_rd && (bus_addr == RA_STATUS);
  assign unused_wdata = ^bus_wdata;

  st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
    .clk(clk), .rst(rst), .tick(slow_tick),
    .presc_wr(wr_pre), .presc_wdata(bus_wdata[PRE_W-1:0]),
    .alarm_wr(wr_alm), .alarm_wdata(bus_wdata[CNT_W-1:0]),
    .cnt(cnt), .presc(presc), .alarm(alarm),
    .inc_evt(inc_evt), .alm_evt(alm_evt));

  st_pit #(.PER_W(PER_W)) u_pit (
    .clk(clk), .rst(rst), .tick(slow_tick),
    .per_wr(wr_per), .per_wdata(bus_wdata[PER_W-1:0]),
    .period(period), .evt(pit_evt));

  st_wdog #(.WD_W(WD_W)) u_wdog (
    .clk(clk), .rst(rst), .tick(slow_tick),
    .ld(wr_wd), .ld_val(bus_wdata[WD_W-1:0]), .evt(wd_evt));

  always_comb begin
    set_v         = '0;
    set_v[FB_PIT] = pit_evt;
    set_v[FB_WDG] = wd_evt;
    set_v[FB_INC] = inc_evt;
    set_v[FB_ALM] = alm_evt;
    // a new event wins over the clear of a same-cycle read
    sts_d  = (rd_sts ? '0 : sts_q) | set_v;
    mask_d = (mask_q | (wr_set ? bus_wdata[NF-1:0] : '0))
             & ~(wr_clr ? bus_wdata[NF-1:0] : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      mask_q <= mask_d;
      irq    <= |(sts_d & mask_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_PERIOD: bus_rdata <= DATA_W'(period);
        RA_PRESC:  bus_rdata <= DATA_W'(presc);
        RA_ALARM:  bus_rdata <= DATA_W'(alarm);
        RA_STATUS: bus_rdata <= DATA_W'(sts_q);
        RA_MASK:   bus_rdata <= DATA_W'(mask_q);
        RA_COUNT:  bus_rdata <= DATA_W'(cnt);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_sts && !slow_tick) |=> (sts_q == '0));
  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    irq == |(sts_q & mask_q));
  assert_alarm_match_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sts_q[FB_ALM]) && $stable(alarm)) |-> (cnt == alarm));
  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_set && !wr_clr) |=> $stable(mask_q));
endmodule

// File: tb/sim_sys_timer.sv
module sim_sys_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sys_timer u0 (
    .clk(clk), .rst(rst), .slow_tick(tick), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  always @(posedge clk) rd_seen <= rd;

  // scoreboard monitor: one expected item per read, due one cycle later
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%0d expected=%0d", t, rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected=end of test", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e,
                          input string t, input bit tk = 1'b0);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd = 1'b1; tick = tk;
    @(negedge clk);
    rd = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_run++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R12 irq after reset");
    bus_read(4'd8, 0, "R1 counter reset");
    bus_read(4'd7, 0, "R10 mask reset");
    bus_read(4'd4, 0, "R12 status reset");
    bus_read(4'd2, 32768, "R2 prescaler reset");
    bus_read(4'd9, 0, "R12 unused address");
    bus_read(4'd0, 0, "R5 period reset");
    // default prescaler
    ticks(32767);
    bus_read(4'd8, 0, "R2 no step before 32768 ticks");
    ticks(1);
    bus_read(4'd8, 1, "R2 step at 32768 ticks");
    bus_read(4'd4, 4, "R7 increment flag");
    bus_read(4'd4, 0, "R8 cleared by read");
    // programmed prescalers
    bus_write(4'd2, 1);
    ticks(5);
    bus_read(4'd8, 6, "R2 prescaler 1");
    bus_write(4'd2, 3);
    ticks(2);
    bus_read(4'd8, 6, "R2 prescaler 3 partial");
    ticks(1);
    bus_read(4'd8, 7, "R2 prescaler 3 step");
    bus_write(4'd2, 1);
    bus_read(4'd4, 4, "R7 flag from prescaler 3 step");
    // alarm
    bus_write(4'd3, 10);
    ticks(2);
    bus_read(4'd4, 4, "R3 no early alarm");
    ticks(1);
    bus_read(4'd4, 12, "R3 alarm at match");
    bus_write(4'd3, 10);
    ticks(1);
    bus_read(4'd4, 4, "R4 armed at current count");
    ticks(50);
    bus_read(4'd4, 4, "R4 still no alarm");
    // mask and irq
    bus_write(4'd5, 8);
    bus_read(4'd7, 8, "R10 mask set");
    bus_write(4'd5, 0);
    bus_read(4'd7, 8, "R10 zero set bits");
    bus_write(4'd6, 0);
    bus_read(4'd7, 8, "R10 zero clear bits");
    bus_write(4'd3, 63);
    ticks(2);
    chk_irq(1'b1, "R11 irq on masked alarm");
    bus_read(4'd4, 12, "R8 status before clear");
    chk_irq(1'b0, "R11 irq drops after read");
    bus_write(4'd3, 65);
    ticks(2);
    chk_irq(1'b1, "R11 irq again");
    bus_write(4'd6, 8);
    chk_irq(1'b0, "R11 irq drops on mask clear");
    bus_read(4'd7, 0, "R10 mask cleared");
    bus_read(4'd4, 12, "R8 status kept while masked");
    // interval timer
    bus_write(4'd0, 4);
    ticks(3);
    bus_read(4'd4, 4, "R5 no interval flag early");
    ticks(1);
    bus_read(4'd4, 5, "R5 interval flag");
    ticks(4);
    bus_read(4'd4, 5, "R5 interval reload");
    bus_write(4'd5, 1);
    ticks(4);
    chk_irq(1'b1, "R11 irq on interval");
    bus_read(4'd4, 5, "R5 interval flag masked");
    bus_write(4'd0, 0);
    bus_write(4'd6, 1);
    ticks(10);
    bus_read(4'd4, 4, "R5 period zero stops");
    // watchdog down-counter
    bus_write(4'd1, 3);
    ticks(2);
    bus_read(4'd4, 4, "R6 not yet zero");
    ticks(1);
    bus_read(4'd4, 6, "R6 reached zero");
    ticks(5);
    bus_read(4'd4, 4, "R6 stays at zero");
    // event in the same cycle as a status read
    bus_read(4'd4, 0, "R9 read returns pre-event flags", 1'b1);
    bus_read(4'd4, 4, "R9 event kept");
    bus_read(4'd8, 96, "R1 counter value");
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule